// File: doc/BRIEF.md
# Bit-Serial Arithmetic Right Shifter

This block divides a bit-serial two's-complement word stream by a fixed power of two. Words arrive one bit per clock, least significant bit first, each `WORD_LEN` bits long. The output stream carries each word arithmetically shifted right by `SHIFT` positions. No storage for a whole word is needed. The output word frame starts `SHIFT + 1` cycles after the input word frame, so the `SHIFT` low input bits fall before the output frame and are never seen in it. Each output bit leaves one register after the input bit it came from. The top `SHIFT` output bits are filled with a held copy of the sign bit.

Two single-cycle pulses from the surrounding sequencer steer the block. `startPulse` marks the cycle in which the sign bit of a word is on `sIn`. `stopPulse` follows exactly `SHIFT` cycles later. Between them the output repeats the captured sign instead of the next word's low bits, which are already arriving. Words may run back to back or be separated by idle cycles.

Top module: `serialShiftDown`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `sOut` is 0 and no sign-hold window is open.
- R2: Outside the sign-hold window, `sOut` in cycle t+1 equals `sIn` in cycle t.
- R3: The bit on `sIn` in the cycle where `startPulse` is high is captured. The first sign-extension output bit equals that bit, whatever `sIn` carries afterwards.
- R4: `startPulse` is a single-cycle pulse and `stopPulse` comes exactly `SHIFT` cycles after it. For the `SHIFT` output cycles from two cycles after `startPulse` through the cycle after `stopPulse`, `sOut` equals the captured sign bit.
- R5: An input word whose first bit (bit 0) is on `sIn` in cycle c appears as an output word with bit i on `sOut` in cycle c+SHIFT+1+i. For a positive word its value is the input value shifted right by `SHIFT`.
- R6: For a negative word, the output word is the input value arithmetically shifted right by `SHIFT` (rounded toward minus infinity), with its top `SHIFT` bits equal to 1.
- R7: The extreme words 0, 1, the largest positive value, the most negative value and -1 produce 0, 0, the largest positive value >> `SHIFT`, the most negative value >>> `SHIFT`, and -1.
- R8: In the cycle after the window ends, `sOut` again follows the delayed input. For back-to-back words this delivers bit `SHIFT` of the following word as bit 0 of its output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sIn | input | 1 | Serial input word stream, LSB first |
| startPulse | input | 1 | High for one cycle while the sign bit is on `sIn` |
| stopPulse | input | 1 | High for one cycle, `SHIFT` cycles after `startPulse` |
| sOut | output | 1 | Serial shifted word stream, LSB first |

## Verification
The hardest case is a sign-hold window that overlaps the next word. Here `sIn` already carries the following word's low bits while the output must still repeat the old sign. If the two signs match, a wrong choice goes unseen. The stimulus therefore places back-to-back words with opposite signs next to each other. It covers the most negative and largest positive values, then a long computed sequence whose neighbours change sign often. Idle gaps between groups show that the window still closes when no word follows.

// File: rtl/shift_down_pkg.sv
package shift_down_pkg;
  // Strobes from the control side to the datapath
  typedef struct packed {
    logic capSign;  // latch the current input bit as the sign
    logic useHold;  // drive the held sign instead of the input
  } shiftStrobeT;
endpackage

// File: rtl/shiftDownCtrl.sv
module shiftDownCtrl
  import shift_down_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startPulse,
  input  logic        stopPulse,
  output shiftStrobeT strobe
);
  logic holdOn;

  // Window opens after the sign-bit cycle and closes after the stop cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           holdOn <= 1'b0;
    else if (startPulse) holdOn <= 1'b1;
    else if (stopPulse)  holdOn <= 1'b0;
  end

  always_comb begin
    strobe.capSign = startPulse;
    strobe.useHold = holdOn;
  end
endmodule

// File: rtl/shiftDownPath.sv
module shiftDownPath
  import shift_down_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sIn,
  input  shiftStrobeT strobe,
  output logic        sOut
);
  logic signHold;
  logic outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               signHold <= 1'b0;
    else if (strobe.capSign) signHold <= sIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outBit <= 1'b0;
    else       outBit <= strobe.useHold ? signHold : sIn;
  end

  assign sOut = outBit;
endmodule

// File: rtl/serialShiftDown.sv
module serialShiftDown
  import shift_down_pkg::*;
#(
  parameter int WORD_LEN = 8,
  parameter int SHIFT    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sIn,
  input  logic startPulse,
  input  logic stopPulse,
  output logic sOut
);
  if (SHIFT < 1 || SHIFT >= WORD_LEN) begin : gBadParam
    $error("serialShiftDown: SHIFT must lie in 1..WORD_LEN-1");
  end

  shiftStrobeT strobe;

  shiftDownCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .stopPulse  (stopPulse),
    .strobe     (strobe)
  );

  shiftDownPath uPath (
    .clk    (clk),
    .rstN   (rstN),
    .sIn    (sIn),
    .strobe (strobe),
    .sOut   (sOut)
  );
endmodule

// File: rtl/shiftDownChk.sv
module shiftDownChk #(
  parameter int WORD_LEN = 8,
  parameter int SHIFT    = 3
) (
  input logic clk,
  input logic rstN,
  input logic sIn,
  input logic startPulse,
  input logic stopPulse,
  input logic sOut
);
  localparam int CW = $clog2(WORD_LEN + 1);

  logic          pastValid;
  logic          chkWin;
  logic          heldSign;
  logic [CW-1:0] sinceStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pastValid  <= 1'b0;
      chkWin     <= 1'b0;
      heldSign   <= 1'b0;
      sinceStart <= '0;
    end else begin
      pastValid <= 1'b1;
      if (startPulse) begin
        chkWin     <= 1'b1;
        heldSign   <= sIn;
        sinceStart <= CW'(1);
      end else begin
        if (stopPulse) chkWin <= 1'b0;
        if (stopPulse)              sinceStart <= '0;
        else if (sinceStart != '0)  sinceStart <= sinceStart + CW'(1);
      end
    end
  end

  AST_RESET_OUT: assert property (@(posedge clk)
    $rose(rstN) |-> (sOut == 1'b0));  // R1

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(chkWin)) |-> (sOut == $past(sIn)));  // R2

  AST_SIGN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(chkWin)) |-> (sOut == heldSign));  // R4

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> !startPulse);  // R4

  AST_STOP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    stopPulse |-> (sinceStart == CW'(SHIFT)));  // R4
endmodule

bind serialShiftDown shiftDownChk #(
  .WORD_LEN (WORD_LEN),
  .SHIFT    (SHIFT)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .sIn        (sIn),
  .startPulse (startPulse),
  .stopPulse  (stopPulse),
  .sOut       (sOut)
);

// File: tb/sim_serialShiftDown.sv
`timescale 1ns/1ps
module sim_serialShiftDown;
  localparam int WL = 8;
  localparam int SH = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sIn = 1'b0;
  logic startPulse = 1'b0;
  logic stopPulse = 1'b0;
  logic sOut;

  always #4 clk = ~clk;  // 125 MHz

  serialShiftDown #(.WORD_LEN(WL), .SHIFT(SH)) u0 (
    .clk(clk), .rstN(rstN), .sIn(sIn),
    .startPulse(startPulse), .stopPulse(stopPulse), .sOut(sOut)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Stimulus schedule and expected output, indexed by cycle
  bit          inBit[int];
  bit          stB[int];
  bit          spB[int];
  bit          expBit[int];
  string       expTag[int];
  logic [WL-1:0] expWord[int];
  string       wordTag[int];
  int          lastCycle = 0;

  function automatic string classify(logic [WL-1:0] w);
    if (w == '0 || w == WL'(1) || &w ||
        w == {1'b0, {(WL-1){1'b1}}} || w == {1'b1, {(WL-1){1'b0}}})
      return "R7";
    return w[WL-1] ? "R6" : "R5";
  endfunction

  task automatic addWord(int c0, logic [WL-1:0] w, bit follows);
    logic signed [WL-1:0] sw;
    logic [WL-1:0] sh;
    sw = w;
    sh = sw >>> SH;
    for (int i = 0; i < WL; i++) inBit[c0 + i] = w[i];
    stB[c0 + WL - 1] = 1'b1;
    spB[c0 + WL - 1 + SH] = 1'b1;
    for (int i = 0; i < WL; i++) begin
      expBit[c0 + SH + 1 + i] = sh[i];
      if (i == WL - SH)      expTag[c0 + SH + 1 + i] = "R3";
      else if (i > WL - SH)  expTag[c0 + SH + 1 + i] = "R4";
      else if (i == 0 && follows) expTag[c0 + SH + 1 + i] = "R8";
      else                   expTag[c0 + SH + 1 + i] = "R2";
    end
    expWord[c0 + SH + WL] = sh;
    wordTag[c0 + SH + WL] = classify(w);
    if (c0 + WL + SH + 4 > lastCycle) lastCycle = c0 + WL + SH + 4;
  endtask

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int c;
    logic [WL-1:0] obs;
    logic [WL-1:0] fixedWords[8];
    fixedWords = '{8'h5A, 8'h7F, 8'h80, 8'hFF, 8'h00, 8'h01, 8'hC3, 8'h81};
    obs = '0;

    // Group 1: fixed words back to back
    c = 2;
    for (int n = 0; n < 8; n++) begin
      addWord(c, fixedWords[n], n > 0);
      c += WL;
    end
    // Group 2: computed words back to back, after an idle gap
    c += 5;
    for (int n = 0; n < 12; n++) begin
      addWord(c, WL'(n * 37 + 11), n > 0);
      c += WL;
    end
    // Group 3: isolated positive word, then an isolated negative word
    c += 3;
    addWord(c, 8'h40, 1'b0);
    c += WL + SH + 2;
    addWord(c, 8'hA6, 1'b0);

    // Reset state (R1)
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sOut == 1'b0, "R1", "sOut in reset", sOut, 0);
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(sOut == 1'b0, "R1", "sOut after reset", sOut, 0);

    for (int cyc = 0; cyc <= lastCycle; cyc++) begin
      // sample output belonging to this cycle
      obs = {sOut, obs[WL-1:1]};
      if (expBit.exists(cyc))
        check(sOut == expBit[cyc], expTag[cyc], $sformatf("bit cycle %0d", cyc),
              sOut, expBit[cyc]);
      if (expWord.exists(cyc))
        check(obs == expWord[cyc], wordTag[cyc], $sformatf("word ending %0d", cyc),
              obs, expWord[cyc]);
      // drive inputs for this cycle
      sIn        = inBit.exists(cyc) ? inBit[cyc] : 1'b0;
      startPulse = stB.exists(cyc) ? stB[cyc] : 1'b0;
      stopPulse  = spB.exists(cyc) ? spB[cyc] : 1'b0;
      @(posedge clk);
      @(negedge clk);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule